// File: doc/BRIEF.md
# SD Card Data-Line Serializer with Per-Lane CRC16

This block moves bytes between a byte-wide FIFO and the data lines of an SD or MMC card, in one-line or four-line mode. Each clock cycle is one bit time on the bus. When transmitting, it sends a frame on every active line: a low start bit, the data bytes of one block, a 16-bit CRC computed separately for that line, and a high end bit. When receiving, it waits for a low start bit on line 0, rebuilds the bytes, recomputes each line's CRC, and compares it with the CRC that arrives.

Software sets four controls. They are a width code, a direction bit, an enable bit and a 12-bit byte count for the block. The width, the direction and the count are captured when a block begins, so changing them during a frame has no effect on that frame. Lines that the current mode does not use are left undriven. Separate one-cycle events mark the end of the data part and the end of the whole frame. A status bit holds the CRC result of the last received block.

Top module: `sd_dat_serdes`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, `busy`, `dat_oe`, `crc_err`, `eob`, `eof`, `rx_valid` and `tx_pop` are all 0.
- R2: `bus_w` = 1 selects four-line mode, with `dat_oe` = 4'b1111 while transmitting. `bus_w` = 0 selects one-line mode, with only line 0 driven (`dat_oe` = 4'b0001). The reserved codes 2 and 3 behave like 0. Width, direction and length are captured when a block begins, and a change during the frame has no effect on it.
- R3: With `en` high in idle and `dir` = 1, a transmit frame starts in the next cycle. It sends one start-bit cycle at 0, the data cycles, 16 CRC cycles and one end-bit cycle at 1, all on the active lines.
- R4: In one-line mode each byte goes out on line 0 with bit 7 first. In four-line mode each byte takes two cycles: bits 7:4 first, then bits 3:0, with the higher bit on the higher line (bit 7 on line 3).
- R5: Each active line carries its own CRC16 (polynomial x^16+x^12+x^5+1, initial value 0), computed over that line's data bits only and sent most significant bit first.
- R6: `tx_pop` is a one-cycle pulse in the first cycle of each byte slot, and `tx_data` is consumed in that cycle. A block makes `blk_len` pops, and `blk_len` = 0 means 4096 bytes.
- R7: With `dir` = 0 the block drives no line. While waiting, it ignores lines 3:1 and starts on a 0 on line 0. Bytes are rebuilt in the R4 order, and each is presented on `rx_data` with a one-cycle `rx_valid` after its last bit.
- R8: At the end of a received frame, `crc_err` becomes 1 if the received CRC differs from the computed CRC on any active line, and 0 otherwise. A transmit frame clears it. It does not change during a frame.
- R9: `eob` pulses for one cycle in the cycle after the last data bit. `eof` pulses for one cycle in the cycle after the end bit.
- R10: When transmitting, `busy` is high from the start-bit cycle through the end-bit cycle. When receiving, it is high from the cycle after the start bit through the cycle in which the end bit is sampled, and is low afterwards.
- R11: With `en` low the block stays idle. A receive wait is abandoned if `en` falls before a start bit arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Line enable; starts or arms a block when idle |
| dir | input | 1 | 1 = transmit, 0 = receive |
| bus_w | input | 2 | Width code: 0 one line, 1 four lines |
| blk_len | input | LEN_W | Bytes per block (0 = 2^LEN_W) |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Consume the head byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` holds a new byte |
| dat_in | input | 4 | Sampled data lines |
| dat_out | output | 4 | Values to drive on the data lines |
| dat_oe | output | 4 | Per-line output enable |
| busy | output | 1 | Frame in progress |
| crc_err | output | 1 | CRC mismatch on the last received block |
| eob | output | 1 | End of data part |
| eof | output | 1 | End of frame |

## Verification
Transmit frames are checked bit by bit against a CRC model in the bench. They cover one-line and four-line width, blocks of one byte and of several bytes, the reserved width code, and a 4096-byte block selected by a zero length. These cases separate errors in nibble order, lane mapping, per-lane CRC and byte counting. Receive frames use the same widths and compare the rebuilt bytes. Some have a flipped CRC bit on line 0 or on line 3, and a clean frame follows a corrupted one. This exposes a missing lane in the comparison and a status that fails to clear. Idle noise on lines 3:1, a receive wait that is abandoned, and a width change during a frame show which inputs the block must ignore.

// File: rtl/sd_dat_serdes.sv
`timescale 1ns/1ps
module sd_dat_serdes #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir,
  input  logic [1:0]       bus_w,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic [3:0]       dat_in,
  output logic [3:0]       dat_out,
  output logic [3:0]       dat_oe,
  output logic             busy,
  output logic             crc_err,
  output logic             eob,
  output logic             eof
);
  localparam logic [15:0] POLY = 16'h1021;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_DATA, S_CRC, S_END} st_t;
  st_t st;

  logic             w4, tx, err;
  logic [3:0]       bitc;
  logic [LEN_W-1:0] rem;
  logic [7:0]       sh;
  logic [3:0][15:0] crc;
  logic [3:0]       ctop, dbit;

  wire [3:0] act      = w4 ? 4'hF : 4'h1;
  wire       last_bit = bitc == (w4 ? 4'd1 : 4'd7);
  wire [7:0] cur      = (tx && bitc == 4'd0) ? tx_data : sh;
  wire [7:0] sh_nx    = tx ? (w4 ? {cur[3:0], 4'h0} : {cur[6:0], 1'b0})
                           : (w4 ? {sh[3:0], dat_in} : {sh[6:0], dat_in[0]});

  always_comb begin
    for (int i = 0; i < 4; i++) ctop[i] = crc[i][15];
    dbit = tx ? (w4 ? cur[7:4] : {3'b111, cur[7]}) : dat_in;
    case (st)
      S_START: dat_out = 4'h0;
      S_DATA:  dat_out = dbit;
      S_CRC:   dat_out = ctop;
      default: dat_out = 4'hF;
    endcase
  end

  assign busy    = st inside {S_START, S_DATA, S_CRC, S_END};
  assign dat_oe  = (tx && busy) ? act : 4'h0;
  assign tx_pop  = tx && st == S_DATA && bitc == 4'd0;
  assign rx_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
      err <= 1'b0;
    end else if (st == S_IDLE) begin
      crc <= '0;
      err <= 1'b0;
    end else if (st == S_DATA) begin
      for (int i = 0; i < 4; i++)
        crc[i] <= {crc[i][14:0], 1'b0} ^ ({16{dbit[i] ^ crc[i][15]}} & POLY);
    end else if (st == S_CRC) begin
      for (int i = 0; i < 4; i++) crc[i] <= {crc[i][14:0], 1'b0};
      if (!tx) err <= err | (|(act & (dat_in ^ ctop)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; w4 <= 1'b0; tx <= 1'b0; bitc <= '0; rem <= '0; sh <= '0;
      rx_valid <= 1'b0; eob <= 1'b0; eof <= 1'b0; crc_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      eob      <= 1'b0;
      eof      <= 1'b0;
      case (st)
        S_IDLE: if (en) begin
          w4   <= bus_w == 2'd1;
          tx   <= dir;
          rem  <= blk_len - 1'b1;
          bitc <= '0;
          st   <= dir ? S_START : S_WAIT;
        end
        S_WAIT: begin
          if (!en) st <= S_IDLE;
          else if (!dat_in[0]) st <= S_DATA;
        end
        S_START: st <= S_DATA;
        S_DATA: begin
          sh <= sh_nx;
          if (last_bit) begin
            bitc     <= '0;
            rx_valid <= !tx;
            if (rem == '0) begin
              st  <= S_CRC;
              eob <= 1'b1;
            end else begin
              rem <= rem - 1'b1;
            end
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
        S_CRC: begin
          bitc <= bitc + 1'b1;
          if (bitc == 4'd15) begin
            bitc <= '0;
            st   <= S_END;
          end
        end
        S_END: begin
          st      <= S_IDLE;
          eof     <= 1'b1;
          crc_err <= !tx && err;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_POP_SPACED:  assert property (@(posedge clk) disable iff (!rst_n) tx_pop |=> !tx_pop); // R6
  AST_RXV_SPACED:  assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R7
  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !tx) |-> dat_oe == 4'h0); // R7
  AST_NARROW_OE:   assert property (@(posedge clk) disable iff (!rst_n) (busy && !w4) |-> dat_oe[3:1] == 3'b000); // R2
  AST_EOB_AT_CRC:  assert property (@(posedge clk) disable iff (!rst_n) eob |-> (st == S_CRC && bitc == 4'd0)); // R9
  AST_EOF_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) eof |-> !busy); // R9
  AST_ERR_HELD:    assert property (@(posedge clk) disable iff (!rst_n) (busy && st != S_END) |=> $stable(crc_err)); // R8
endmodule

// File: tb/sd_dat_serdes_bench.sv
`timescale 1ns/1ps
module sd_dat_serdes_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, dir = 1'b0;
  logic [1:0] bus_w = 2'd0;
  logic [11:0] blk_len = 12'd1;
  logic [7:0] tx_data = 8'h00;
  logic [3:0] dat_in = 4'hF;
  logic tx_pop, rx_valid, busy, crc_err, eob, eof;
  logic [7:0] rx_data;
  logic [3:0] dat_out, dat_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_dat_serdes #(.LEN_W(12)) u_sd_dat_serdes (
    .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .bus_w(bus_w), .blk_len(blk_len),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .busy(busy),
    .crc_err(crc_err), .eob(eob), .eof(eof));

  // {dir, bus_w, blk_len, seed, corrupt lane+1 (0 = clean)}
  localparam logic [25:0] VEC [10] = '{
    {1'b1, 2'd0, 12'd1, 8'd3,  3'd0},
    {1'b1, 2'd1, 12'd1, 8'd5,  3'd0},
    {1'b1, 2'd1, 12'd5, 8'd9,  3'd0},
    {1'b1, 2'd0, 12'd3, 8'd17, 3'd0},
    {1'b0, 2'd0, 12'd2, 8'd4,  3'd0},
    {1'b0, 2'd1, 12'd4, 8'd7,  3'd0},
    {1'b0, 2'd1, 12'd3, 8'd8,  3'd4},
    {1'b0, 2'd0, 12'd2, 8'd2,  3'd1},
    {1'b0, 2'd1, 12'd2, 8'd11, 3'd0},
    {1'b1, 2'd2, 12'd2, 8'd6,  3'd0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int n);
    int v;
    v = int'(seed) * 37 + n * 29 + n / 7;
    return v[7:0];
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic run_tx(input logic [1:0] w, input logic [11:0] len, input logic [7:0] seed);
    logic w4;
    int bpc, nb, n, total, bad_fr, bad_d, bad_c, bad_oe, bad_busy, bad_pop, pops, eobs, eob_k;
    logic [3:0] mask, exp;
    logic [15:0] c [4];
    logic [7:0] by;
    w4 = (w == 2'd1); bpc = w4 ? 2 : 8; nb = (len == 0) ? 4096 : int'(len);
    n = nb * bpc; total = n + 18; mask = w4 ? 4'hF : 4'h1;
    bad_fr = 0; bad_d = 0; bad_c = 0; bad_oe = 0; bad_busy = 0; bad_pop = 0; pops = 0; eobs = 0; eob_k = -1;
    for (int i = 0; i < 4; i++) c[i] = 16'h0;
    @(negedge clk); dir = 1'b1; bus_w = w; blk_len = len; tx_data = pat(seed, 0); en = 1'b1;
    @(negedge clk); en = 1'b0; bus_w = w4 ? 2'd0 : 2'd1;   // width change mid-frame, R2
    for (int k = 1; k <= total; k++) begin
      if (k > 1) @(negedge clk);
      if (tx_pop) pops++;
      if (eob) begin eobs++; eob_k = k; end
      if (k == 1) begin
        exp = 4'h0;
        if (tx_pop) bad_pop++;
      end else if (k <= n + 1) begin
        int d, s;
        d = k - 2; s = d % bpc; by = pat(seed, d / bpc);
        exp = w4 ? (s == 0 ? by[7:4] : by[3:0]) : {3'b000, by[7-s]};
        if (tx_pop != (s == 0)) bad_pop++;
        for (int i = 0; i < 4; i++) c[i] = crc_step(c[i], exp[i]);
        tx_data = pat(seed, (d + 1) / bpc);
      end else if (k <= n + 17) begin
        int cc;
        cc = k - n - 2;
        for (int i = 0; i < 4; i++) exp[i] = c[i][15-cc];
        if (tx_pop) bad_pop++;
      end else begin
        exp = 4'hF;
        if (tx_pop) bad_pop++;
      end
      if ((dat_out & mask) != (exp & mask)) begin
        if (k == 1 || k == total) bad_fr++;
        else if (k <= n + 1) bad_d++;
        else bad_c++;
      end
      if (dat_oe != mask) bad_oe++;
      if (!busy) bad_busy++;
    end
    chk(bad_fr == 0, "R3 start/end bits", bad_fr, 0);
    chk(bad_d == 0, "R4 data bit order", bad_d, 0);
    chk(bad_c == 0, "R5 per-lane CRC", bad_c, 0);
    chk(bad_oe == 0, "R2 output enables", bad_oe, 0);
    chk(bad_busy == 0, "R10 busy during tx frame", bad_busy, 0);
    chk(bad_pop == 0, "R6 pop placement", bad_pop, 0);
    chk(pops == nb, "R6 pop count", pops, nb);
    chk(eobs == 1 && eob_k == n + 2, "R9 eob timing", eob_k, n + 2);
    @(negedge clk);
    chk(eof && !busy, "R9 eof after end bit", {eof, busy}, 2'b10);
    chk(dat_oe == 4'h0 && !tx_pop, "R10 released after tx", dat_oe, 0);
    chk(!crc_err, "R8 tx clears crc_err", crc_err, 0);
  endtask

  task automatic run_rx(input logic [1:0] w, input logic [11:0] len, input logic [7:0] seed,
                        input logic [2:0] corr);
    logic w4;
    int bpc, nb, n, rcnt, bad_rx, bad_busy, bad_oe, bad_wait, eobs, eob_t;
    logic [3:0] mask, v;
    logic [15:0] c [4];
    logic [7:0] by;
    w4 = (w == 2'd1); bpc = w4 ? 2 : 8; nb = (len == 0) ? 4096 : int'(len);
    n = nb * bpc; mask = w4 ? 4'hF : 4'h1;
    rcnt = 0; bad_rx = 0; bad_busy = 0; bad_oe = 0; bad_wait = 0; eobs = 0; eob_t = -1;
    for (int i = 0; i < 4; i++) c[i] = 16'h0;
    @(negedge clk); dir = 1'b0; bus_w = w; blk_len = len; en = 1'b1; dat_in = 4'b0001;
    repeat (3) begin
      @(negedge clk);
      if (busy || dat_oe != 4'h0) bad_wait++;
    end
    chk(bad_wait == 0, "R7 wait ignores lines 3:1", bad_wait, 0);
    for (int t = 0; t <= n + 17; t++) begin
      if (t > 0) begin
        @(negedge clk);
        if (rx_valid) begin
          if (rx_data != pat(seed, rcnt)) bad_rx++;
          rcnt++;
        end
        if (!busy) bad_busy++;
        if (dat_oe != 4'h0) bad_oe++;
        if (eob) begin eobs++; eob_t = t; end
      end
      if (t == 0) dat_in = ~mask;
      else if (t <= n) begin
        int d, s;
        d = t - 1; s = d % bpc; by = pat(seed, d / bpc);
        v = w4 ? (s == 0 ? by[7:4] : by[3:0]) : {3'b111, by[7-s]};
        for (int i = 0; i < 4; i++) c[i] = crc_step(c[i], v[i]);
        dat_in = v;
      end else if (t <= n + 16) begin
        int cc;
        cc = t - n - 1;
        for (int i = 0; i < 4; i++) v[i] = c[i][15-cc];
        if (corr != 3'd0 && cc == 5) v[corr-1] = ~v[corr-1];
        dat_in = v | ~mask;
      end else begin
        dat_in = 4'hF; en = 1'b0;
      end
    end
    chk(bad_rx == 0, "R7 received bytes", bad_rx, 0);
    chk(bad_oe == 0, "R7 no drive in rx", bad_oe, 0);
    chk(bad_busy == 0, "R10 busy during rx frame", bad_busy, 0);
    chk(eobs == 1 && eob_t == n + 1, "R9 eob in rx", eob_t, n + 1);
    @(negedge clk);
    chk(rcnt == nb, "R7 byte count", rcnt, nb);
    chk(eof && !busy, "R9 eof in rx / R10 busy low", {eof, busy}, 2'b10);
    chk(crc_err == (corr != 3'd0), "R8 crc status", crc_err, corr != 3'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && dat_oe == 0 && !crc_err && !eob && !eof && !rx_valid && !tx_pop,
        "R1 outputs in reset", {busy, dat_oe, crc_err, eob, eof, rx_valid, tx_pop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && dat_oe == 0 && !crc_err && !eob && !eof && !rx_valid && !tx_pop,
        "R1 outputs after reset", {busy, dat_oe, crc_err, eob, eof, rx_valid, tx_pop}, 0);

    for (int i = 0; i < 10; i++) begin
      logic [25:0] vv;
      vv = VEC[i];
      if (vv[25]) run_tx(vv[24:23], vv[22:11], vv[10:3]);
      else        run_rx(vv[24:23], vv[22:11], vv[10:3], vv[2:0]);
    end

    // R11: enable low keeps the block idle
    @(negedge clk); dir = 1'b1; en = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !tx_pop && dat_oe == 0, "R11 idle with en low", {busy, tx_pop, dat_oe}, 0);

    // R11: receive wait abandoned when en falls
    dir = 1'b0; en = 1'b1; dat_in = 4'hF;
    repeat (2) @(negedge clk);
    en = 1'b0; dat_in = 4'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !rx_valid, "R11 abandoned wait", {busy, rx_valid}, 0);
    dat_in = 4'hF;

    // R6: zero length selects 4096 bytes
    run_tx(2'd1, 12'd0, 8'd21);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule